// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block keeps the nine status and control flags of a legacy 32-bit processor running in its 16-bit compatible mode. On each valid operation it takes two operands, an operation code and a data size of 8, 16 or 32 bits. It recomputes carry, parity, auxiliary carry, zero, sign and overflow from the result of an add, subtract, AND, OR or XOR at that size. It also holds the trap, interrupt-enable and direction flags. Only explicit set and clear commands change those three.

The block presents the flags as a 32-bit word with fixed bit positions. It also supplies a signed step for string address updates. The step equals the access size in bytes and is negated while the direction flag is set. The operand path only does what the flags need. Instruction decode is handled elsewhere.

Top module: `arith_flag_unit`

## Requirements
- R1: After reset the flag word is 32'h0000_0002. With opSize=0, stringStep reads +1.
- R2: Flag positions are CF=0, PF=2, AF=4, ZF=6, SF=7, TF=8, IF=9, DF=10 and OF=11. Bit 1 always reads 1 and every other bit reads 0.
- R3: For add (opCode=0), CF is the carry out of the sized result. For subtract (opCode=1), CF is the borrow, meaning the unsigned first operand is below the second. opSize 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Only the low bits of each operand at that size are used.
- R4: PF is 1 when the low 8 bits of the result hold an even number of ones, at every size.
- R5: For add and subtract, AF is 1 on a carry out of bit 3 (add) or a borrow into bit 4 (subtract).
- R6: ZF is 1 when the sized result is zero. SF copies the result's top bit at the selected size.
- R7: For add and subtract, OF is 1 when the signed result does not fit the selected size.
- R8: For AND (2), OR (3) and XOR (4), CF and OF are cleared, AF keeps its value, and PF, ZF and SF follow the result.
- R9: ctlCmd codes are: 1 sets TF, 2 clears TF, 3 sets IF, 4 clears IF, 5 sets DF and 6 clears DF. Codes 0 and 7 do nothing. Commands touch no arithmetic flag, and operations touch none of TF, IF or DF. A command and an operation in the same cycle both take effect.
- R10: stringStep is +1, +2 or +4 for opSize 0, 1 and 2/3, in two's complement. It is negated while DF is 1, and it follows opSize and DF without delay.
- R11: With opValid low, or with opCode 5 to 7, the arithmetic flags do not change.
- R12: An operation shows in flagWord only after the rising clock edge on which opValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 3 | 0 add, 1 sub, 2 and, 3 or, 4 xor |
| opSize | input | 2 | 0 byte, 1 word, 2/3 dword |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| ctlCmd | input | 3 | Control flag set/clear command |
| flagWord | output | 32 | Registered flag word |
| stringStep | output | 32 | Signed string address step |

## Verification
The bench targets carries and borrows at each size boundary: 0x7F+1, 0xFF+1, 0x8000-1, 0-1 and their 16- and 32-bit versions. A design that took the carry from the wrong bit would show CF or OF wrong at the smaller sizes. An 8-bit sweep of all first operands against spread second operands exposes a wrong nibble carry, or parity taken over the whole word instead of the low byte. Logic operations that follow an operation which set AF show whether AF is wrongly cleared. Mixed commands, invalid opcodes and idle cycles catch control flags that leak into arithmetic updates, and catch flags that change when they should hold.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int CF_POS = 0;
  localparam int ONE_POS = 1;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int TF_POS = 8;
  localparam int IF_POS = 9;
  localparam int DF_POS = 10;
  localparam int OF_POS = 11;

  localparam logic [2:0] OPC_ADD = 3'd0;
  localparam logic [2:0] OPC_SUB = 3'd1;
  localparam logic [2:0] OPC_AND = 3'd2;
  localparam logic [2:0] OPC_OR  = 3'd3;
  localparam logic [2:0] OPC_XOR = 3'd4;

  typedef enum logic [1:0] {
    LSEL_AND = 2'd0,
    LSEL_OR  = 2'd1,
    LSEL_XOR = 2'd2
  } logicSel_e;

  typedef struct packed {
    logic      arithUpd;
    logic      isSub;
    logic      logicUpd;
    logicSel_e logicSel;
    logic      tfSet;
    logic      tfClr;
    logic      ifSet;
    logic      ifClr;
    logic      dfSet;
    logic      dfClr;
  } flagStrobe_t;
endpackage

// File: rtl/afu_ctrl.sv
module afu_ctrl
  import afu_pkg::*;
(
  input  logic        opValid,
  input  logic [2:0]  opCode,
  input  logic [2:0]  ctlCmd,
  output flagStrobe_t stb
);
  always_comb begin
    stb = '0;
    stb.logicSel = LSEL_AND;
    if (opValid) begin
      unique case (opCode)
        OPC_ADD: stb.arithUpd = 1'b1;
        OPC_SUB: begin stb.arithUpd = 1'b1; stb.isSub = 1'b1; end
        OPC_AND: begin stb.logicUpd = 1'b1; stb.logicSel = LSEL_AND; end
        OPC_OR:  begin stb.logicUpd = 1'b1; stb.logicSel = LSEL_OR; end
        OPC_XOR: begin stb.logicUpd = 1'b1; stb.logicSel = LSEL_XOR; end
        default: ;
      endcase
    end
    case (ctlCmd)
      3'd1: stb.tfSet = 1'b1;
      3'd2: stb.tfClr = 1'b1;
      3'd3: stb.ifSet = 1'b1;
      3'd4: stb.ifClr = 1'b1;
      3'd5: stb.dfSet = 1'b1;
      3'd6: stb.dfClr = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/afu_datapath.sv
module afu_datapath
  import afu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  flagStrobe_t       stb,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [31:0]       flagWord,
  output logic [31:0]       stringStep
);
  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W-1:0] sizeMask, aM, bM, arithRes, logicRes, res;
  logic [EXT_W-1:0]  rawExt;
  logic carryOut, resMsb, aMsb, bMsb;
  logic cfQ, pfQ, afQ, zfQ, sfQ, tfQ, ifQ, dfQ, ofQ;
  logic nCf, nPf, nAf, nZf, nSf, nOf;
  logic [31:0] stepBytes;

  assign aM = opA & sizeMask;
  assign bM = opB & sizeMask;
  assign rawExt = stb.isSub ? ({1'b0, aM} - {1'b0, bM}) : ({1'b0, aM} + {1'b0, bM});
  assign arithRes = rawExt[DATA_W-1:0] & sizeMask;

  always_comb begin
    unique case (stb.logicSel)
      LSEL_OR:  logicRes = aM | bM;
      LSEL_XOR: logicRes = aM ^ bM;
      default:  logicRes = aM & bM;
    endcase
  end

  assign res = stb.arithUpd ? arithRes : logicRes;

  always_comb begin
    case (opSize)
      2'd0: begin
        sizeMask = DATA_W'(8'hFF);
        carryOut = rawExt[8];
        resMsb = res[7]; aMsb = aM[7]; bMsb = bM[7];
        stepBytes = 32'd1;
      end
      2'd1: begin
        sizeMask = DATA_W'(16'hFFFF);
        carryOut = rawExt[16];
        resMsb = res[15]; aMsb = aM[15]; bMsb = bM[15];
        stepBytes = 32'd2;
      end
      default: begin
        sizeMask = '1;
        carryOut = rawExt[DATA_W];
        resMsb = res[DATA_W-1]; aMsb = aM[DATA_W-1]; bMsb = bM[DATA_W-1];
        stepBytes = 32'd4;
      end
    endcase
  end

  always_comb begin
    nPf = ~^res[7:0];
    nZf = (res == '0);
    nSf = resMsb;
    if (stb.arithUpd) begin
      nCf = carryOut;
      nAf = aM[4] ^ bM[4] ^ arithRes[4];
      nOf = stb.isSub ? ((aMsb != bMsb) && (resMsb != aMsb))
                      : ((aMsb == bMsb) && (resMsb != aMsb));
    end else begin
      nCf = 1'b0;
      nAf = afQ;
      nOf = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cfQ, pfQ, afQ, zfQ, sfQ, tfQ, ifQ, dfQ, ofQ} <= '0;
    end else begin
      if (stb.arithUpd || stb.logicUpd) begin
        cfQ <= nCf; pfQ <= nPf; afQ <= nAf;
        zfQ <= nZf; sfQ <= nSf; ofQ <= nOf;
      end
      if (stb.tfSet) tfQ <= 1'b1; else if (stb.tfClr) tfQ <= 1'b0;
      if (stb.ifSet) ifQ <= 1'b1; else if (stb.ifClr) ifQ <= 1'b0;
      if (stb.dfSet) dfQ <= 1'b1; else if (stb.dfClr) dfQ <= 1'b0;
    end
  end

  always_comb begin
    flagWord = '0;
    flagWord[ONE_POS] = 1'b1;
    flagWord[CF_POS] = cfQ;
    flagWord[PF_POS] = pfQ;
    flagWord[AF_POS] = afQ;
    flagWord[ZF_POS] = zfQ;
    flagWord[SF_POS] = sfQ;
    flagWord[TF_POS] = tfQ;
    flagWord[IF_POS] = ifQ;
    flagWord[DF_POS] = dfQ;
    flagWord[OF_POS] = ofQ;
  end

  assign stringStep = dfQ ? (32'd0 - stepBytes) : stepBytes;

  // R11: no strobe of any kind leaves the whole word unchanged
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.arithUpd || stb.logicUpd || stb.tfSet || stb.tfClr || stb.ifSet ||
      stb.ifClr || stb.dfSet || stb.dfClr) |=> $stable(flagWord));
  // R8: a logic op leaves carry and overflow cleared
  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb.logicUpd |=> (!flagWord[CF_POS] && !flagWord[OF_POS]));
  // R8: a logic op keeps auxiliary carry
  assert_logic_keeps_af_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb.logicUpd |=> $stable(flagWord[AF_POS]));
  // R10: setting direction makes the step negative on the next cycle
  assert_step_negative_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stb.dfSet |=> stringStep[31]);
  // R4, R6: a zero result has even parity and a clear sign
  assert_zero_implies_pf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flagWord[ZF_POS] |-> (flagWord[PF_POS] && !flagWord[SF_POS]));
  // R9: control commands never move the arithmetic flags
  assert_cmd_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.arithUpd || stb.logicUpd) |=> $stable({flagWord[OF_POS], flagWord[7:0]}));
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        ctlCmd,
  output logic [31:0]       flagWord,
  output logic [31:0]       stringStep
);
  flagStrobe_t stb;

  afu_ctrl uCtrl (
    .opValid(opValid),
    .opCode(opCode),
    .ctlCmd(ctlCmd),
    .stb(stb)
  );

  afu_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk),
    .rst_n(rst_n),
    .stb(stb),
    .opSize(opSize),
    .opA(opA),
    .opB(opB),
    .flagWord(flagWord),
    .stringStep(stringStep)
  );
endmodule

// File: tb/sim_arith_flag_unit.sv
module sim_arith_flag_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic opValid = 1'b0;
  logic [2:0] opCode = '0;
  logic [1:0] opSize = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [2:0] ctlCmd = '0;
  logic [31:0] flagWord, stringStep;

  int total = 0;
  int bad = 0;
  logic [31:0] expW = 32'h2;

  always #10 clk = ~clk;

  arith_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .opSize(opSize), .opA(opA), .opB(opB), .ctlCmd(ctlCmd),
    .flagWord(flagWord), .stringStep(stringStep)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tagFor(input logic [31:0] diff, input int code);
    for (int i = 0; i < 32; i++) begin
      if (diff[i]) begin
        if (code >= 2 && code <= 4 && (i == 0 || i == 4 || i == 11)) return "R8";
        case (i)
          0: return "R3";
          2: return "R4";
          4: return "R5";
          6, 7: return "R6";
          8, 9, 10: return "R9";
          11: return "R7";
          default: return "R2";
        endcase
      end
    end
    return "R2";
  endfunction

  function automatic logic [31:0] model(input logic [31:0] prev, input int code,
      input int size, input logic [31:0] a, input logic [31:0] b);
    longint unsigned mask, am, bm, r, full;
    longint sa, sb, sr, half;
    int n, ones;
    logic cf, af, of;
    logic [31:0] w;
    if (code > 4) return prev;
    n = (size == 0) ? 8 : (size == 1) ? 16 : 32;
    mask = (64'd1 << n) - 64'd1;
    half = longint'(64'd1 << (n - 1));
    am = {32'd0, a} & mask;
    bm = {32'd0, b} & mask;
    sa = (longint'(am) >= half) ? longint'(am) - 2 * half : longint'(am);
    sb = (longint'(bm) >= half) ? longint'(bm) - 2 * half : longint'(bm);
    cf = 1'b0; of = 1'b0; af = prev[4];
    case (code)
      0: begin
        full = am + bm; r = full & mask; cf = (full > mask);
        af = ((am & 15) + (bm & 15)) > 15;
        sr = sa + sb; of = (sr >= half) || (sr < -half);
      end
      1: begin
        r = (am - bm) & mask; cf = (am < bm);
        af = (am & 15) < (bm & 15);
        sr = sa - sb; of = (sr >= half) || (sr < -half);
      end
      2: r = am & bm;
      3: r = am | bm;
      default: r = am ^ bm;
    endcase
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    w = prev;
    w[0] = cf; w[2] = (ones % 2 == 0); w[4] = af;
    w[6] = (r == 0); w[7] = r[n-1]; w[11] = of;
    return w;
  endfunction

  function automatic logic [31:0] applyCmd(input logic [31:0] prev, input int cmd);
    logic [31:0] w = prev;
    case (cmd)
      1: w[8] = 1'b1;
      2: w[8] = 1'b0;
      3: w[9] = 1'b1;
      4: w[9] = 1'b0;
      5: w[10] = 1'b1;
      6: w[10] = 1'b0;
      default: ;
    endcase
    return w;
  endfunction

  task automatic doOp(input int code, input int size, input logic [31:0] a,
      input logic [31:0] b, input int cmd, input logic valid);
    @(negedge clk);
    opValid = valid; opCode = 3'(code); opSize = 2'(size);
    opA = a; opB = b; ctlCmd = 3'(cmd);
    if (valid) expW = model(expW, code, size, a, b);
    expW = applyCmd(expW, cmd);
    @(negedge clk);
    opValid = 1'b0; ctlCmd = 3'd0;
    if (flagWord !== expW) chk(tagFor(flagWord ^ expW, code), flagWord, expW);
    else chk("R3", flagWord, expW);
  endtask

  task automatic stepChk(input int size, input logic df);
    logic [31:0] e;
    @(negedge clk);
    opSize = 2'(size);
    #1;
    e = (size == 0) ? 32'd1 : (size == 1) ? 32'd2 : 32'd4;
    if (df) e = 32'd0 - e;
    chk("R10", stringStep, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", flagWord, 32'h0000_0002);
    chk("R1", stringStep, 32'd1);

    // R3 R4 R5 R6 R7 R8: byte sweep over every first operand
    for (int code = 0; code < 5; code++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 32; j++)
          doOp(code, 0, 32'(a), 32'((j * 8 + (j >> 2)) & 255), 0, 1'b1);

    // R3 R7: size-boundary corners
    doOp(0, 0, 32'h7F, 32'h1, 0, 1'b1);
    doOp(0, 1, 32'h7FFF, 32'h1, 0, 1'b1);
    doOp(0, 1, 32'hFFFF, 32'h1, 0, 1'b1);
    doOp(1, 1, 32'h8000, 32'h1, 0, 1'b1);
    doOp(1, 1, 32'h0, 32'h1, 0, 1'b1);
    doOp(0, 2, 32'h7FFF_FFFF, 32'h1, 0, 1'b1);
    doOp(0, 3, 32'hFFFF_FFFF, 32'h1, 0, 1'b1);
    doOp(1, 2, 32'h8000_0000, 32'h1, 0, 1'b1);
    doOp(1, 2, 32'h0, 32'h1, 0, 1'b1);
    doOp(0, 0, 32'h1234_56FF, 32'hABCD_0001, 0, 1'b1);

    // word and dword patterns, upper operand bits ignored at smaller size
    for (int i = 0; i < 600; i++)
      for (int code = 0; code < 5; code++) begin
        doOp(code, 1, 32'(i) * 32'h9E37_79B9, (32'(i) * 32'd7919) ^ 32'h0000_8000, 0, 1'b1);
        doOp(code, 2 + (i & 1), 32'(i) * 32'h85EB_CA6B, 32'(i) * 32'hC2B2_AE35, 0, 1'b1);
      end

    // R8: AF survives a logic op after being set
    doOp(0, 0, 32'h0F, 32'h01, 0, 1'b1);
    doOp(3, 0, 32'h80, 32'h00, 0, 1'b1);

    // R9: commands, alone and together with operations
    for (int c = 0; c < 8; c++) doOp(0, 0, 32'h0, 32'h0, c, 1'b0);
    doOp(1, 0, 32'h00, 32'h01, 1, 1'b1);
    doOp(0, 0, 32'hFF, 32'h01, 3, 1'b1);
    doOp(4, 1, 32'hAAAA, 32'h5555, 5, 1'b1);

    // R10: step follows size and direction
    for (int s = 0; s < 4; s++) stepChk(s, 1'b1);
    doOp(0, 0, 32'h0, 32'h0, 6, 1'b0);
    for (int s = 0; s < 4; s++) stepChk(s, 1'b0);

    // R11: idle cycles and undefined opcodes leave flags alone
    doOp(0, 0, 32'hFF, 32'h01, 0, 1'b1);
    for (int c = 5; c < 8; c++) doOp(c, 0, 32'h7F, 32'h01, 0, 1'b1);
    doOp(0, 0, 32'h7F, 32'h01, 0, 1'b0);

    // R12: no change before the capturing edge
    @(negedge clk);
    opValid = 1'b1; opCode = 3'd1; opSize = 2'd0; opA = 32'h0; opB = 32'h1;
    #5;
    chk("R12", flagWord, expW);
    expW = model(expW, 1, 0, 32'h0, 32'h1);
    @(negedge clk);
    opValid = 1'b0;
    chk("R12", flagWord, expW);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule